// File: doc/BRIEF.md
# Double-Buffered Serial Repeat-Transfer Engine

This block is a clocked synchronous serial master that shifts a byte out and a byte in at the same time on every frame. It drives a serial clock that idles high, a serial data output, and samples a serial data input. Software loads outgoing bytes through a one-entry transmit holding buffer. It reads incoming bytes either from a receive holding buffer or straight from the shift register. A busy status bit and a one-cycle completion pulse per frame report progress. The serial clock is the system clock divided by a fixed parameter.

In repeat mode the first byte written while idle goes straight into the shift register. Two transfer requests are raised at once, so the holding buffer is free for the next byte immediately. Frames then chain back to back. At each slot boundary the engine continues only if the holding buffer has been refilled. The latest moment to refill is the reservation window: it opens with the completion pulse and closes at the first clock edge of the next slot. On a handoff, the byte received in the frame just finished moves to the receive buffer. When no refill arrives, the run stops and the final frame's byte stays only in the shift register.

In single mode each frame's received byte is copied to the receive buffer as that frame ends. This includes the last frame of a run.

Top module: `sxfer_engine`

## Requirements
- R1: After reset the serial clock and serial data output are high, busy and the completion pulse are low, and both the receive buffer and the shift-register read port read zero.
- R2: A transmit write while idle loads the byte straight into the shift register. The first falling clock edge, with the byte's MSB on the data output, appears in the cycle after the write. The holding buffer can take another byte from the next cycle on.
- R3: A frame is 8 bits, MSB first. The data output changes on falling serial clock edges and the data input is sampled on rising edges. Each half serial clock period lasts HALF_DIV system cycles, so a frame slot is 16*HALF_DIV cycles.
- R4: The completion pulse lasts exactly one cycle per frame. It appears together with the frame's eighth rising clock edge.
- R5: If the holding buffer holds a byte at a slot boundary, the next frame starts at that boundary with no gap. A write in the reservation window, up to and including the boundary cycle itself, counts as a refill.
- R6: In repeat mode, the receive buffer takes the previous frame's received byte in the same cycle as the handoff to the next frame, and not earlier.
- R7: In repeat mode, a slot boundary with no refill ends the run. Busy falls, the clock stays high, and the data output returns high. The receive buffer keeps the byte from the frame before last, and the shift-register read port shows the final frame's byte.
- R8: In single mode, the receive buffer takes each frame's byte at its eighth rising edge, including the last frame of the run.
- R9: A write that lands while the holding buffer still holds an unsent byte replaces it. The replaced byte is never transmitted.
- R10: The pending request count never exceeds two. A full holding buffer always has a pending request. A stopped run leaves no requests and an empty buffer, so a write one cycle after a stop starts a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| repeat_en | input | 1 | 1 selects repeat mode, 0 single mode; latched when a run starts |
| tx_wr | input | 1 | Transmit holding buffer write strobe |
| tx_wdata | input | W | Transmit byte |
| rx_rdata | output | W | Receive holding buffer |
| shift_rdata | output | W | Direct read of the shift register |
| busy | output | 1 | High while a run is in progress |
| done_irq | output | 1 | One-cycle completion pulse per frame |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data output |
| sdi | input | 1 | Serial data input |

## Verification
Assertions check the request bookkeeping on every cycle: at most two requests, a full buffer always backed by a request, and an empty state while idle. They also check that the completion pulse is one cycle wide and high-clock aligned, that the clock idles high, and that the receive buffer is copied from or frozen against the shift register at handoff, single-mode frame end and repeat stop. Only the bench scenarios can show the cycle position of the slot boundary and of the reservation window. That includes a refill on the boundary cycle versus one cycle late, the byte order on the wire against an independent serial peer, and the fact that an overwritten byte never leaves the block.

// File: rtl/sxfer_pkg.sv
package sxfer_pkg;

  typedef enum logic {
    SX_IDLE = 1'b0,
    SX_RUN  = 1'b1
  } sx_state_e;

  localparam int unsigned SX_REQ_MAX = 2;

  typedef logic [1:0] sx_req_t;

  // Add new requests, drop one consumed request, saturate at SX_REQ_MAX.
  function automatic sx_req_t sx_req_step(input sx_req_t cur,
                                          input logic [1:0] inc,
                                          input logic dec);
    logic [2:0] sum;
    sum = {1'b0, cur} + {1'b0, inc} - {2'b00, dec};
    if (sum > 3'(SX_REQ_MAX)) begin
      sum = 3'(SX_REQ_MAX);
    end
    return sum[1:0];
  endfunction

endpackage

// File: rtl/sxfer_rst_sync.sv
module sxfer_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;

endmodule

// File: rtl/sxfer_half_timer.sv
module sxfer_half_timer #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic half_done
);

  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CMAX = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  always_comb begin
    wrap = (cnt_q == CMAX);
    if (!run || restart || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    half_done = run && !restart && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: the divider never leaves its half-period range
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);

endmodule

// File: rtl/sxfer_ctrl.sv
module sxfer_ctrl
  import sxfer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         repeat_en,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_wdata,
  input  logic         half_done,
  output logic         run,
  output logic         rpt,
  output logic         sclk,
  output logic         start,
  output logic         load,
  output logic [W-1:0] load_data,
  output logic         rise,
  output logic         fall,
  output logic         last_rise,
  output logic         handoff,
  output logic         stop,
  output logic         irq
);

  localparam int unsigned NEDGE = 2 * W;
  localparam int unsigned PHW   = $clog2(NEDGE);
  localparam logic [PHW-1:0] PH_LAST = PHW'(NEDGE - 2);
  localparam logic [PHW-1:0] PH_END  = PHW'(NEDGE - 1);

  sx_state_e      st_q, st_d;
  logic [PHW-1:0] ph_q, ph_d;
  sx_req_t        pend_q, pend_d;
  logic [W-1:0]   tx_buf_q, tx_buf_d;
  logic           tx_full_q, tx_full_d;
  logic           rpt_q, rpt_d;
  logic           sclk_q, sclk_d;
  logic           irq_q, irq_d;

  logic           bound;
  logic           have_next;
  logic [1:0]     req_inc;

  // event decode
  always_comb begin
    run       = (st_q == SX_RUN);
    start     = !run && tx_wr;
    rise      = run && half_done && !ph_q[0];
    last_rise = rise && (ph_q == PH_LAST);
    fall      = run && half_done && ph_q[0] && (ph_q != PH_END);
    bound     = run && half_done && (ph_q == PH_END);
    have_next = tx_full_q || tx_wr;
    handoff   = bound && have_next;
    stop      = bound && !have_next;
    load      = start || handoff;
    load_data = tx_full_q ? tx_buf_q : tx_wdata;
  end

  // next state
  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    rpt_d     = rpt_q;
    sclk_d    = sclk_q;
    tx_buf_d  = tx_buf_q;
    tx_full_d = tx_full_q;
    irq_d     = last_rise;

    if (start) begin
      st_d  = SX_RUN;
      rpt_d = repeat_en;
    end else if (stop) begin
      st_d = SX_IDLE;
    end

    if (load) begin
      ph_d   = '0;
      sclk_d = 1'b0;
    end else if (rise) begin
      ph_d   = ph_q + 1'b1;
      sclk_d = 1'b1;
    end else if (fall) begin
      ph_d   = ph_q + 1'b1;
      sclk_d = 1'b0;
    end

    if (handoff && tx_full_q) begin
      tx_full_d = 1'b0;
    end
    if (tx_wr && !start && !(handoff && !tx_full_q)) begin
      tx_buf_d  = tx_wdata;
      tx_full_d = 1'b1;
    end

    if (!tx_wr) begin
      req_inc = 2'd0;
    end else if (start && repeat_en) begin
      req_inc = 2'd2;
    end else begin
      req_inc = 2'd1;
    end

    if (stop) begin
      pend_d = '0;
    end else begin
      pend_d = sx_req_step(pend_q, req_inc, load);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SX_IDLE;
      ph_q      <= '0;
      pend_q    <= '0;
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      rpt_q     <= 1'b0;
      sclk_q    <= 1'b1;
      irq_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      ph_q      <= ph_d;
      pend_q    <= pend_d;
      tx_buf_q  <= tx_buf_d;
      tx_full_q <= tx_full_d;
      rpt_q     <= rpt_d;
      sclk_q    <= sclk_d;
      irq_q     <= irq_d;
    end
  end

  assign rpt  = rpt_q;
  assign sclk = sclk_q;
  assign irq  = irq_q;

  // R10: request count bounded
  a_r10_pend_max: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= sx_req_t'(SX_REQ_MAX));

  // R10: a held byte is always backed by a pending request
  a_r10_full_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full_q |-> (pend_q != '0));

  // R10: idle means no requests and an empty buffer
  a_r10_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pend_q == '0) && !tx_full_q);

  // R4: completion pulse is one cycle wide
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R2: a write while idle starts a frame on the next edge
  a_r2_start_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && tx_wr) |=> (run && !sclk_q && (ph_q == '0)));

  // R7: the serial clock idles high
  a_r7_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sclk_q);

endmodule

// File: rtl/sxfer_shifter.sv
module sxfer_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         rise,
  input  logic         fall,
  input  logic         stop,
  input  logic         hold_copy,
  input  logic         live_copy,
  input  logic         sdi,
  output logic [W-1:0] sh_out,
  output logic [W-1:0] rx_out,
  output logic         sdo
);

  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] rx_q, rx_d;
  logic         sdo_q, sdo_d;
  logic [W-1:0] sh_shifted;

  always_comb begin
    sh_shifted = {sh_q[W-2:0], sdi};
    sh_d  = sh_q;
    rx_d  = rx_q;
    sdo_d = sdo_q;

    if (load) begin
      sh_d  = load_data;
      sdo_d = load_data[W-1];
    end else if (rise) begin
      sh_d = sh_shifted;
    end else if (fall) begin
      sdo_d = sh_q[W-1];
    end else if (stop) begin
      sdo_d = 1'b1;
    end

    if (hold_copy) begin
      rx_d = sh_q;
    end else if (live_copy) begin
      rx_d = sh_shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rx_q  <= '0;
      sdo_q <= 1'b1;
    end else begin
      sh_q  <= sh_d;
      rx_q  <= rx_d;
      sdo_q <= sdo_d;
    end
  end

  assign sh_out = sh_q;
  assign rx_out = rx_q;
  assign sdo    = sdo_q;

endmodule

// File: rtl/sxfer_engine.sv
module sxfer_engine #(
  parameter int unsigned W        = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         repeat_en,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_wdata,
  output logic [W-1:0] rx_rdata,
  output logic [W-1:0] shift_rdata,
  output logic         busy,
  output logic         done_irq,
  output logic         sclk,
  output logic         sdo,
  input  logic         sdi
);

  logic         rst_n;
  logic         run;
  logic         rpt;
  logic         start;
  logic         load;
  logic [W-1:0] load_data;
  logic         rise;
  logic         fall;
  logic         last_rise;
  logic         handoff;
  logic         stop;
  logic         half_done;
  logic         hold_copy;
  logic         live_copy;

  sxfer_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  sxfer_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .restart   (start),
    .half_done (half_done)
  );

  sxfer_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .repeat_en (repeat_en),
    .tx_wr     (tx_wr),
    .tx_wdata  (tx_wdata),
    .half_done (half_done),
    .run       (run),
    .rpt       (rpt),
    .sclk      (sclk),
    .start     (start),
    .load      (load),
    .load_data (load_data),
    .rise      (rise),
    .fall      (fall),
    .last_rise (last_rise),
    .handoff   (handoff),
    .stop      (stop),
    .irq       (done_irq)
  );

  assign hold_copy = handoff && rpt;
  assign live_copy = last_rise && !rpt;

  sxfer_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .rise      (rise),
    .fall      (fall),
    .stop      (stop),
    .hold_copy (hold_copy),
    .live_copy (live_copy),
    .sdi       (sdi),
    .sh_out    (shift_rdata),
    .rx_out    (rx_rdata),
    .sdo       (sdo)
  );

  assign busy = run;

  // R6: repeat handoff moves the finished frame's byte into the receive buffer
  a_r6_handoff_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff && rpt) |=> (rx_rdata == $past(shift_rdata)));

  // R7: repeat stop leaves the receive buffer untouched
  a_r7_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && rpt) |=> $stable(rx_rdata));

  // R8: single mode copies the completed frame as it ends
  a_r8_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (last_rise && !rpt) |=> (rx_rdata == shift_rdata));

  // R4: completion pulse coincides with the high clock phase
  a_r4_irq_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> sclk);

endmodule

// File: tb/sxfer_engine_bench.sv
module sxfer_engine_bench;

  localparam int unsigned W = 8;
  localparam int unsigned H = 4;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         repeat_en = 1'b0;
  logic         tx_wr = 1'b0;
  logic [W-1:0] tx_wdata = '0;
  logic [W-1:0] rx_rdata;
  logic [W-1:0] shift_rdata;
  logic         busy;
  logic         done_irq;
  logic         sclk;
  logic         sdo;
  logic         sdi = 1'b0;

  int checks = 0;
  int errors = 0;
  int now    = 0;

  logic [W-1:0] exp_tx_q[$];
  logic [W-1:0] slv_q[$];

  always #2.5 clk = ~clk;

  sxfer_engine #(.W(W), .HALF_DIV(H)) u_sxfer_engine (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .repeat_en   (repeat_en),
    .tx_wr       (tx_wr),
    .tx_wdata    (tx_wdata),
    .rx_rdata    (rx_rdata),
    .shift_rdata (shift_rdata),
    .busy        (busy),
    .done_irq    (done_irq),
    .sclk        (sclk),
    .sdo         (sdo),
    .sdi         (sdi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic advance_to(input int k);
    while (now < k) begin
      @(negedge clk);
      now++;
    end
  endtask

  task automatic pulse_wr(input logic [W-1:0] d, input bit expect_sent);
    tx_wr    = 1'b1;
    tx_wdata = d;
    if (expect_sent) exp_tx_q.push_back(d);
    @(negedge clk);
    tx_wr = 1'b0;
    now++;
  endtask

  task automatic gap();
    repeat (6) @(negedge clk);
    now = -1;
  endtask

  // serial peer: drives sdi on falling edges
  int slv_n = 0;
  logic [W-1:0] slv_cur = '0;
  always @(negedge sclk) begin
    if (rst_ni) begin
      if (slv_n == 0) slv_cur = (slv_q.size() != 0) ? slv_q.pop_front() : '0;
      sdi = slv_cur[W-1-slv_n];
      slv_n = (slv_n + 1) % W;
    end
  end

  // scoreboard monitor: collects sdo on rising edges, compares whole bytes
  int mon_n = 0;
  logic [W-1:0] mon_sh = '0;
  always @(posedge sclk) begin
    if (rst_ni && busy) begin
      mon_sh = {mon_sh[W-2:0], sdo};
      mon_n++;
      if (mon_n == W) begin
        mon_n = 0;
        if (exp_tx_q.size() == 0) chk("R3 R9 unexpected frame", {24'h0, mon_sh}, 32'hFFFF);
        else chk("R3 R9 wire byte", {24'h0, mon_sh}, {24'h0, exp_tx_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 sclk", sclk, 1);
    chk("R1 sdo", sdo, 1);
    chk("R1 busy", busy, 0);
    chk("R1 irq", done_irq, 0);
    chk("R1 rx", rx_rdata, 0);
    chk("R1 shift", shift_rdata, 0);

    // Scenario A: repeat run of four frames, refills at various points
    repeat_en = 1'b1;
    slv_q.push_back(8'h3C); slv_q.push_back(8'hA5);
    slv_q.push_back(8'h0F); slv_q.push_back(8'hC3);
    now = -1;
    pulse_wr(8'h96, 1);
    chk("R2 busy after write", busy, 1);
    chk("R2 first falling edge", sclk, 0);
    chk("R2 msb on sdo", sdo, 1);
    advance_to(H - 1);
    chk("R3 low half", sclk, 0);
    advance_to(H);
    chk("R3 first rising edge", sclk, 1);
    advance_to(5);
    pulse_wr(8'h5A, 1);            // buffer free during frame 1
    advance_to(15 * H - 1);
    chk("R4 irq before last rise", done_irq, 0);
    advance_to(15 * H);
    chk("R4 irq at last rise", done_irq, 1);
    advance_to(15 * H + 1);
    chk("R4 irq one cycle", done_irq, 0);
    advance_to(16 * H - 1);
    chk("R6 rx not copied early", rx_rdata, 0);
    advance_to(16 * H);
    chk("R5 frame 2 starts at boundary", sclk, 0);
    chk("R5 busy held", busy, 1);
    chk("R6 rx at handoff", rx_rdata, 8'h3C);
    advance_to(31 * H);
    chk("R4 irq frame 2", done_irq, 1);
    advance_to(31 * H + 1);
    pulse_wr(8'hE1, 1);            // inside reservation window
    advance_to(32 * H);
    chk("R5 window refill continues", sclk, 0);
    chk("R6 rx frame 2", rx_rdata, 8'hA5);
    advance_to(48 * H - 1);
    pulse_wr(8'h7A, 1);            // lands on the boundary cycle
    chk("R5 boundary refill continues", busy, 1);
    chk("R5 boundary refill clock", sclk, 0);
    chk("R6 rx frame 3", rx_rdata, 8'h0F);
    advance_to(64 * H - 1);
    chk("R7 busy before stop", busy, 1);
    advance_to(64 * H);
    chk("R7 busy falls", busy, 0);
    chk("R7 sclk idle", sclk, 1);
    chk("R7 sdo idle", sdo, 1);
    chk("R7 rx keeps frame 3", rx_rdata, 8'h0F);
    chk("R7 shift holds frame 4", shift_rdata, 8'hC3);

    // Scenario B: single repeat frame, then a write one cycle after stop
    gap();
    slv_q.push_back(8'h81); slv_q.push_back(8'h42);
    pulse_wr(8'h11, 1);
    advance_to(16 * H);
    chk("R7 single frame stops", busy, 0);
    chk("R7 rx unchanged", rx_rdata, 8'h0F);
    pulse_wr(8'h22, 1);            // one cycle too late: fresh run
    chk("R10 fresh run starts", busy, 1);
    chk("R10 fresh run clock", sclk, 0);
    advance_to(32 * H);
    chk("R10 fresh run busy", busy, 1);
    advance_to(32 * H + 1);
    chk("R10 fresh run stops", busy, 0);
    chk("R7 shift final byte", shift_rdata, 8'h42);

    // Scenario C: single mode, two frames
    gap();
    repeat_en = 1'b0;
    slv_q.push_back(8'h99); slv_q.push_back(8'h66);
    pulse_wr(8'h33, 1);
    pulse_wr(8'h44, 1);            // buffer free the cycle after the start
    advance_to(15 * H - 1);
    chk("R8 rx before frame end", rx_rdata, 8'h0F);
    advance_to(15 * H);
    chk("R8 rx at frame end", rx_rdata, 8'h99);
    chk("R8 irq with copy", done_irq, 1);
    advance_to(16 * H);
    chk("R5 single mode chains", busy, 1);
    advance_to(31 * H);
    chk("R8 rx final frame", rx_rdata, 8'h66);
    advance_to(32 * H);
    chk("R8 run ends", busy, 0);

    // Scenario D: overwrite of an unsent byte
    gap();
    repeat_en = 1'b1;
    slv_q.push_back(8'h12); slv_q.push_back(8'h34);
    pulse_wr(8'h55, 1);
    pulse_wr(8'hFF, 0);            // replaced before it is sent
    pulse_wr(8'hAA, 1);
    advance_to(32 * H - 1);
    chk("R9 two frames only", busy, 1);
    advance_to(32 * H);
    chk("R9 stop after replacement", busy, 0);
    chk("R9 rx first frame", rx_rdata, 8'h12);
    repeat (4) @(negedge clk);
    chk("R9 all expected bytes seen", exp_tx_q.size(), 0);

    finish_run();
  end

endmodule